// File: doc/BRIEF.md
# Configuration Transaction Engine

This block gives software three registers for reaching configuration values on boards: a data word, a command word and a two-bit status word. A board is picked by site, and an item on that board by device number. Software first places a value in the data word if the command is a write. It then writes the command word with its launch bit set. The engine checks that the target exists and performs the transfer in that same cycle.

A transfer can reach several targets. Oscillator entries can be read or written: six on the motherboard and a parameterised number on daughterboard 1. Voltage readings are read-only. Shutdown and reboot requests come out as one-cycle pulses, and two no-op functions are accepted. The status word reports completion. It also carries an error flag when the target is unsupported. All three registers appear directly as outputs, so no read path is needed.

Top module: `cfg_xact_engine`

## Requirements
- R1: After reset, the data, command and status registers read 0 and both request pulses are low. Motherboard oscillators 0 to 5 reset to 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000. Daughterboard oscillator i resets to word i of `DB_OSC_INIT`.
- R2: A write to the command register (`reg_sel`=1) stores the word with bits 31, 19 and 18 forced to 0. The command fields are: bit 31 launch, bit 30 direction (1 write, 0 read), bits 29:26 chain, bits 25:20 function, bits 17:16 site, bits 15:12 position and bits 11:0 device.
- R3: A command write with the launch bit set makes status bit 0 equal 1 after that clock edge. Status bit 1 is set when the target is unsupported and cleared otherwise. A command write without the launch bit leaves the status unchanged.
- R4: A transfer fails if the chain is nonzero, the position is nonzero, or the site is not 0 (motherboard) or 1 (daughterboard 1).
- R5: Function 1 on site 0 with device 0 to 5 reads the motherboard oscillator entry into the data register. In the write direction, it stores the data register into that entry. Device 6 or higher fails.
- R6: Function 1 on site 1 reaches daughterboard oscillator entries 0 to `DB_OSC_COUNT`-1. Any higher device fails.
- R7: Function 2 is a read-only voltage query. Site 0 with device 0 returns 3300000. Site 1 with a device below `DB_VOLT_COUNT` returns word `device` of `DB_VOLT_VAL`. The write direction and all other targets fail.
- R8: A write-direction transfer with function 8 (shutdown) or function 9 (reboot) on site 0, device 0 raises the matching output for exactly one cycle. Any other site or device fails and raises nothing.
- R9: Functions 7 and 11 in the write direction on site 0, device 0 complete without error and change no other state. Read-direction transfers of those functions fail.
- R10: A write to the status register (`reg_sel`=2) stores bits 1:0 of the written word.
- R11: A successful read updates the data register on the same edge that sets the status. A failed read leaves the data register unchanged.
- R12: A write to the data register (`reg_sel`=0) stores the whole word. Any function other than 1, 2, 7, 8, 9 or 11 fails. A write with `reg_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 data, 1 command, 2 status |
| reg_wdata | input | 32 | Write data |
| data_q | output | 32 | Data register |
| ctrl_q | output | 32 | Command register |
| stat_q | output | 2 | Status: bit 0 complete, bit 1 error |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The bench builds the engine with three daughterboard oscillators and two daughterboard voltage sensors. With these values, the first out-of-range daughterboard device number is 3, which is not a power of two. This shows that the bound is a true comparison and not a wrap of the index bits. The two distinct voltage words also confirm that the word order in `DB_VOLT_VAL` is applied correctly. Written oscillator values are read back to show that entries are stored separately.

// File: rtl/cfg_xact_engine.sv
module cfg_xact_engine #(
  parameter int DB_OSC_COUNT = 2,
  parameter logic [32*DB_OSC_COUNT-1:0] DB_OSC_INIT = {32'd40000000, 32'd60000000},
  parameter int DB_VOLT_COUNT = 2,
  parameter logic [32*DB_VOLT_COUNT-1:0] DB_VOLT_VAL = {32'd900000, 32'd1000000}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] data_q,
  output logic [31:0] ctrl_q,
  output logic [1:0]  stat_q,
  output logic        shutdown_req,
  output logic        reboot_req
);
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam int MB_OSC = 6;
  localparam int DBW = (DB_OSC_COUNT > 1) ? $clog2(DB_OSC_COUNT) : 1;
  localparam int VW  = (DB_VOLT_COUNT > 1) ? $clog2(DB_VOLT_COUNT) : 1;
  localparam logic [31:0] KEEP_MASK = 32'h7FF3_FFFF;
  localparam logic [31:0] MB_VOLT = 32'd3300000;

  logic [31:0] mb_osc [MB_OSC];
  logic [31:0] db_osc [DB_OSC_COUNT];

  wire        c_start = reg_wdata[31];
  wire        c_wr    = reg_wdata[30];
  wire [3:0]  c_chain = reg_wdata[29:26];
  wire [5:0]  c_fn    = reg_wdata[25:20];
  wire [1:0]  c_site  = reg_wdata[17:16];
  wire [3:0]  c_pos   = reg_wdata[15:12];
  wire [11:0] c_dev   = reg_wdata[11:0];

  wire launch   = reg_wr && reg_sel == SEL_CTRL && c_start;
  wire path_ok  = c_chain == 4'd0 && c_pos == 4'd0;
  wire on_mb    = path_ok && c_site == 2'd0;
  wire on_db    = path_ok && c_site == 2'd1;
  wire dev0     = c_dev == 12'd0;
  wire mb_in    = c_dev < 12'(MB_OSC);
  wire db_in    = c_dev < 12'(DB_OSC_COUNT);
  wire volt_in  = c_dev < 12'(DB_VOLT_COUNT);
  wire [2:0]     mb_idx = c_dev[2:0];
  wire [DBW-1:0] db_idx = c_dev[DBW-1:0];
  wire [VW-1:0]  v_idx  = c_dev[VW-1:0];

  logic        xok, wr_mb, wr_db, do_shut, do_boot;
  logic [31:0] rd_val;

  always_comb begin
    xok = 1'b0; wr_mb = 1'b0; wr_db = 1'b0;
    do_shut = 1'b0; do_boot = 1'b0; rd_val = '0;
    case (c_fn)
      6'd1: begin
        if (on_mb && mb_in) begin
          xok = 1'b1; wr_mb = c_wr;
          if (mb_idx < 3'(MB_OSC)) rd_val = mb_osc[mb_idx];
        end else if (on_db && db_in) begin
          xok = 1'b1; wr_db = c_wr;
          if (32'(db_idx) < DB_OSC_COUNT) rd_val = db_osc[db_idx];
        end
      end
      6'd2: if (!c_wr) begin
        if (on_mb && dev0) begin
          xok = 1'b1; rd_val = MB_VOLT;
        end else if (on_db && volt_in) begin
          xok = 1'b1;
          if (32'(v_idx) < DB_VOLT_COUNT) rd_val = DB_VOLT_VAL[32*v_idx +: 32];
        end
      end
      6'd7, 6'd11: xok = c_wr && on_mb && dev0;
      6'd8: begin xok = c_wr && on_mb && dev0; do_shut = xok; end
      6'd9: begin xok = c_wr && on_mb && dev0; do_boot = xok; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; ctrl_q <= '0; stat_q <= '0;
      shutdown_req <= 1'b0; reboot_req <= 1'b0;
      for (int i = 0; i < MB_OSC; i++)
        mb_osc[i] <= (i == 0) ? 32'd50000000 : (i == 1) ? 32'd23750000 : 32'd24000000;
      for (int i = 0; i < DB_OSC_COUNT; i++)
        db_osc[i] <= DB_OSC_INIT[32*i +: 32];
    end else begin
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
      if (reg_wr) begin
        case (reg_sel)
          SEL_DATA: data_q <= reg_wdata;
          SEL_CTRL: begin
            ctrl_q <= reg_wdata & KEEP_MASK;
            if (c_start) begin
              stat_q <= {~xok, 1'b1};
              if (xok && !c_wr) data_q <= rd_val;
              if (wr_mb && mb_idx < 3'(MB_OSC)) mb_osc[mb_idx] <= data_q;
              if (wr_db && 32'(db_idx) < DB_OSC_COUNT) db_osc[db_idx] <= data_q;
              shutdown_req <= do_shut;
              reboot_req   <= do_boot;
            end
          end
          SEL_STAT: stat_q <= reg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  p_launch_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> stat_q[0]);
  p_bad_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !path_ok) |=> stat_q == 2'b11);
  p_stat_low_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_STAT) |=> stat_q == $past(reg_wdata[1:0]));
  p_failed_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !c_wr && !xok) |=> $stable(data_q));
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_req || reboot_req) |=> !(shutdown_req || reboot_req));
  p_pulse_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reboot_req));
  p_ctrl_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_CTRL) |=> (!ctrl_q[31] && ctrl_q[19:18] == 2'b00));
endmodule

// File: tb/cfg_xact_engine_tb.sv
`timescale 1ns/1ps
module cfg_xact_engine_tb;
  localparam int NDB = 3;
  localparam int NV  = 2;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] data_q, ctrl_q;
  logic [1:0] stat_q;
  logic shutdown_req, reboot_req;

  always #2.5 clk = ~clk;

  cfg_xact_engine #(
    .DB_OSC_COUNT(NDB),
    .DB_OSC_INIT({32'd33000000, 32'd45000000, 32'd60000000}),
    .DB_VOLT_COUNT(NV),
    .DB_VOLT_VAL({32'd1800000, 32'd1000000})
  ) u_dut (.*);

  int checks = 0, errors = 0;
  longint unsigned m_mb [6];
  longint unsigned m_db [NDB];
  longint unsigned m_volt [NV];
  logic [31:0] e_data, e_ctrl;
  logic [1:0]  e_stat;
  bit e_shut, e_boot;

  function automatic logic [31:0] mk(bit st, bit wr, int ch, int fn, int site, int pos, int dev);
    return {st, wr, 4'(ch), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model(bit wr, logic [1:0] sel, logic [31:0] v);
    int fn, site, dev; bit ok, dir; longint unsigned rv;
    e_shut = 0; e_boot = 0;
    if (!wr) return;
    if (sel == 0) e_data = v;
    else if (sel == 2) e_stat = v[1:0];
    else if (sel == 1) begin
      e_ctrl = v;
      e_ctrl[31] = 0; e_ctrl[19] = 0; e_ctrl[18] = 0;
      if (v[31]) begin
        fn = int'(v[25:20]); site = int'(v[17:16]); dev = int'(v[11:0]); dir = v[30];
        ok = 0; rv = 0;
        if (v[29:26] == 0 && v[15:12] == 0) begin
          if (fn == 1 && site == 0 && dev < 6) begin
            ok = 1; if (dir) m_mb[dev] = e_data; else rv = m_mb[dev];
          end else if (fn == 1 && site == 1 && dev < NDB) begin
            ok = 1; if (dir) m_db[dev] = e_data; else rv = m_db[dev];
          end else if (fn == 2 && !dir && site == 0 && dev == 0) begin
            ok = 1; rv = 3300000;
          end else if (fn == 2 && !dir && site == 1 && dev < NV) begin
            ok = 1; rv = m_volt[dev];
          end else if ((fn == 7 || fn == 8 || fn == 9 || fn == 11) && dir && site == 0 && dev == 0) begin
            ok = 1; e_shut = (fn == 8); e_boot = (fn == 9);
          end
        end
        e_stat = {~ok, 1'b1};
        if (ok && !dir) e_data = 32'(rv);
      end
    end
  endtask

  task automatic step(bit wr, logic [1:0] sel, logic [31:0] v, string tag);
    reg_wr = wr; reg_sel = sel; reg_wdata = v;
    @(posedge clk);
    model(wr, sel, v);
    @(negedge clk);
    reg_wr = 0;
    cmp(tag, "data", data_q, e_data);
    cmp(tag, "ctrl", ctrl_q, e_ctrl);
    cmp(tag, "stat", 32'(stat_q), 32'(e_stat));
    cmp(tag, "shutdown", 32'(shutdown_req), 32'(e_shut));
    cmp(tag, "reboot", 32'(reboot_req), 32'(e_boot));
  endtask

  task automatic idle(string tag);
    step(0, 2'd0, 32'h0, tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_mb[0] = 50000000; m_mb[1] = 23750000;
    for (int i = 2; i < 6; i++) m_mb[i] = 24000000;
    m_db[0] = 60000000; m_db[1] = 45000000; m_db[2] = 33000000;
    m_volt[0] = 1000000; m_volt[1] = 1800000;
    e_data = 0; e_ctrl = 0; e_stat = 0; e_shut = 0; e_boot = 0;
    repeat (3) @(negedge clk);
    cmp("R1", "reset data", data_q, 0);
    cmp("R1", "reset stat", 32'(stat_q), 0);
    rst_n = 1'b1;
    idle("R1");
    // R2: undefined bits dropped, no launch keeps status
    step(1, 2'd1, 32'h7FFF_FFFF, "R2");
    step(1, 2'd1, 32'hFFFF_FFFF & ~32'h4000_0000 & ~32'h3C00_0000 & ~32'h0000_F000, "R2");
    // R1 and R5: motherboard oscillator reset values
    for (int d = 0; d < 6; d++) step(1, 2'd1, mk(1, 0, 0, 1, 0, 0, d), "R1");
    step(1, 2'd1, mk(1, 0, 0, 1, 0, 0, 6), "R5");
    // R5: write then read back
    step(1, 2'd0, 32'd12345678, "R12");
    step(1, 2'd1, mk(1, 1, 0, 1, 0, 0, 3), "R5");
    step(1, 2'd0, 32'hDEAD_BEEF, "R12");
    step(1, 2'd1, mk(1, 0, 0, 1, 0, 0, 3), "R5");
    step(1, 2'd1, mk(1, 0, 0, 1, 0, 0, 2), "R5");
    // R6: daughterboard oscillators
    for (int d = 0; d < 4; d++) step(1, 2'd1, mk(1, 0, 0, 1, 1, 0, d), "R6");
    step(1, 2'd0, 32'd77000000, "R6");
    step(1, 2'd1, mk(1, 1, 0, 1, 1, 0, 2), "R6");
    step(1, 2'd1, mk(1, 0, 0, 1, 1, 0, 2), "R6");
    step(1, 2'd1, mk(1, 1, 0, 1, 1, 0, 3), "R6");
    // R7: voltages
    step(1, 2'd1, mk(1, 0, 0, 2, 0, 0, 0), "R7");
    step(1, 2'd1, mk(1, 0, 0, 2, 1, 0, 1), "R7");
    step(1, 2'd1, mk(1, 0, 0, 2, 1, 0, 0), "R7");
    step(1, 2'd1, mk(1, 0, 0, 2, 1, 0, 2), "R7");
    step(1, 2'd1, mk(1, 1, 0, 2, 0, 0, 0), "R7");
    step(1, 2'd1, mk(1, 0, 0, 2, 0, 0, 1), "R7");
    // R4: rejected routes
    step(1, 2'd1, mk(1, 0, 1, 1, 0, 0, 0), "R4");
    step(1, 2'd1, mk(1, 0, 0, 1, 0, 2, 0), "R4");
    step(1, 2'd1, mk(1, 0, 0, 1, 2, 0, 0), "R4");
    step(1, 2'd1, mk(1, 1, 0, 1, 3, 0, 0), "R4");
    // R8: shutdown and reboot pulses
    step(1, 2'd1, mk(1, 1, 0, 8, 0, 0, 0), "R8");
    idle("R8");
    step(1, 2'd1, mk(1, 1, 0, 9, 0, 0, 0), "R8");
    idle("R8");
    step(1, 2'd1, mk(1, 1, 0, 8, 1, 0, 0), "R8");
    step(1, 2'd1, mk(1, 1, 0, 9, 0, 0, 1), "R8");
    step(1, 2'd1, mk(1, 0, 0, 8, 0, 0, 0), "R8");
    // R9: accepted no-ops
    step(1, 2'd1, mk(1, 1, 0, 7, 0, 0, 0), "R9");
    step(1, 2'd1, mk(1, 1, 0, 11, 0, 0, 0), "R9");
    step(1, 2'd1, mk(1, 0, 0, 11, 0, 0, 0), "R9");
    step(1, 2'd1, mk(1, 0, 0, 1, 0, 0, 3), "R9");
    // R10: status write
    step(1, 2'd2, 32'hFFFF_FFFC, "R10");
    step(1, 2'd2, 32'h0000_0007, "R10");
    step(1, 2'd2, 32'h0000_0001, "R10");
    // R11: failed read keeps data, successful read loads it
    step(1, 2'd0, 32'hA5A5_5A5A, "R11");
    step(1, 2'd1, mk(1, 0, 0, 1, 0, 0, 9), "R11");
    step(1, 2'd1, mk(1, 0, 0, 1, 0, 0, 0), "R11");
    // R12: unknown functions and unused select
    step(1, 2'd1, mk(1, 1, 0, 5, 0, 0, 0), "R12");
    step(1, 2'd1, mk(1, 0, 0, 63, 0, 0, 0), "R12");
    step(1, 2'd3, 32'hFFFF_FFFF, "R12");
    step(1, 2'd1, mk(0, 1, 0, 8, 0, 0, 0), "R3");
    idle("R3");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule